// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block tracks the coherence state of a small direct-mapped set of cache lines for one processor on a shared bus. Every line is Modified, Shared or Invalid. The processor side presents read and write requests with an address. The block answers a request at once when the line is already usable. Otherwise it stalls the processor and runs the bus transactions the protocol needs: a fetch for reading, a fetch-for-ownership, and a write-back of a dirty victim. When the fetch ends, the line state is updated and the request is evaluated again.

At the same time the block watches the transactions that other caches place on the bus. A remote read that hits a dirty local line makes the block push that line to memory and demote it to Shared. A remote ownership request invalidates the local copy, and the line is also pushed first when it was dirty. The bus is expected to raise its completion only after any remote holder has flushed. A miss therefore completes only once memory is current. The line states are exported as a flat vector so that the surrounding cache can track them.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every line is Invalid (code 0 in `line_st_o`, two bits per line, line i at bits 2i+1:2i), `busy_o` is low and `bus_req_o` is low.
- R2: A read whose line is Invalid or holds another tag, with a victim that is not Modified, raises `miss_o` and `busy_o` and issues a read (`bus_op_o` = 1) for the request address. After `bus_done_i` the line is Shared (code 1).
- R3: A write to a line that is absent or Shared issues an ownership request (`bus_op_o` = 2) for the request address. After `bus_done_i` the line is Modified (code 2).
- R4: A read that hits a Shared or Modified line, and a write that hits a Modified line, raise `hit_o` in the same cycle with `busy_o` and `bus_req_o` low, and leave the state unchanged.
- R5: A miss whose indexed line is Modified under another tag first issues a write-back (`bus_op_o` = 3) with the victim's address. After its `bus_done_i` the victim is Invalid, and only then is the read or ownership request for the new address issued.
- R6: A snooped read (`snp_op_i` = 1) that hits a Modified line raises `flush_o` with `flush_addr_o` equal to the snooped address, and the line becomes Shared.
- R7: A snooped ownership request (`snp_op_i` = 2) that hits a valid line makes it Invalid. `flush_o` is raised only when the line was Modified.
- R8: A snoop that misses the tag, hits an Invalid line, is a read hitting a Shared line, or is a write-back (`snp_op_i` = 3) changes no state and raises no flush.
- R9: While a bus transaction is pending, `busy_o` and `bus_req_o` stay high and the operation and address stay stable until `bus_done_i`. Only one miss is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Processor request present |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | ADDR_W | Request line address (low IDX_W bits index) |
| hit_o | output | 1 | Request served without bus traffic |
| miss_o | output | 1 | Request needs bus traffic; a transaction starts |
| busy_o | output | 1 | Processor must hold and wait |
| bus_req_o | output | 1 | Own bus transaction pending |
| bus_op_o | output | 2 | 1 read, 2 ownership, 3 write-back |
| bus_addr_o | output | ADDR_W | Address of own transaction |
| bus_done_i | input | 1 | Own transaction finished (remote flush included) |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_op_i | input | 2 | Snooped operation, same codes as bus_op_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| flush_o | output | 1 | Local dirty line must be pushed to memory |
| flush_addr_o | output | ADDR_W | Address of the line to push |
| line_st_o | output | 2*2**IDX_W | Per-line state, 0 Invalid, 1 Shared, 2 Modified |

## Verification
The assertions assume that the processor holds its request steady while `busy_o` is high. They also assume that `bus_done_i` pulses only while `bus_req_o` is high, and that no snooped transaction targets the victim line during its write-back. The bench issues one request or one snoop at a time and drives snoops only while the controller is idle. It raises completion after several wait cycles, so these assumptions always hold. The sweep visits every line index, every starting state, both request kinds, all snoop kinds, and both matching and foreign tags.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} line_st_e;
  typedef enum logic [1:0] {
    BUS_NONE = 2'd0, BUS_RD = 2'd1, BUS_RDX = 2'd2, BUS_WB = 2'd3
  } bus_op_e;
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array import msi_pkg::*; #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  localparam int LINES = 1 << IDX_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          snp_valid_i,
  input  bus_op_e                       snp_op_i,
  input  logic [IDX_W-1:0]              snp_idx_i,
  input  logic [TAG_W-1:0]              snp_tag_i,
  input  logic                          fill_en_i,
  input  logic [IDX_W-1:0]              fill_idx_i,
  input  logic [TAG_W-1:0]              fill_tag_i,
  input  line_st_e                      fill_st_i,
  output logic [LINES-1:0][1:0]         st_o,
  output logic [LINES-1:0][TAG_W-1:0]   tag_o,
  output logic                          flush_o
);
  logic [LINES-1:0] fl;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e         st_q;
    logic [TAG_W-1:0] tag_q;
    logic             hit;

    assign hit   = snp_valid_i && (snp_idx_i == IDX_W'(g)) && (tag_q == snp_tag_i) && (st_q != LS_I);
    assign fl[g] = hit && (st_q == LS_M) && (snp_op_i == BUS_RD || snp_op_i == BUS_RDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= LS_I;
        tag_q <= '0;
      end else if (fill_en_i && fill_idx_i == IDX_W'(g)) begin
        // own completion beats a snoop on the same index
        st_q  <= fill_st_i;
        tag_q <= fill_tag_i;
      end else if (hit) begin
        if (snp_op_i == BUS_RDX)                     st_q <= LS_I;
        else if (snp_op_i == BUS_RD && st_q == LS_M) st_q <= LS_S;
      end
    end

    assign st_o[g]  = st_q;
    assign tag_o[g] = tag_q;
  end

  assign flush_o = |fl;
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm import msi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  line_st_e          cur_st_i,
  input  logic [TAG_W-1:0]  cur_tag_i,
  input  logic              bus_done_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              busy_o,
  output logic              bus_req_o,
  output bus_op_e           bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              fill_en_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output line_st_e          fill_st_o
);
  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_FETCH} fsm_e;

  fsm_e              fsm_q;
  logic [ADDR_W-1:0] pend_q, vic_q;
  logic              wr_q;
  logic              tag_hit, ok, need_wb;

  assign tag_hit = (cur_tag_i == req_addr_i[ADDR_W-1:IDX_W]) && (cur_st_i != LS_I);
  assign ok      = tag_hit && (!req_write_i || cur_st_i == LS_M);
  assign need_wb = !tag_hit && (cur_st_i == LS_M);

  assign hit_o  = (fsm_q == F_IDLE) && req_valid_i && ok;
  assign miss_o = (fsm_q == F_IDLE) && req_valid_i && !ok;
  assign busy_o = (fsm_q != F_IDLE) || miss_o;

  assign bus_req_o  = (fsm_q != F_IDLE);
  assign bus_op_o   = (fsm_q == F_EVICT) ? BUS_WB : (fsm_q == F_FETCH) ? (wr_q ? BUS_RDX : BUS_RD) : BUS_NONE;
  assign bus_addr_o = (fsm_q == F_EVICT) ? vic_q : pend_q;

  assign fill_en_o  = bus_req_o && bus_done_i;
  assign fill_idx_o = pend_q[IDX_W-1:0];
  assign fill_tag_o = (fsm_q == F_EVICT) ? vic_q[ADDR_W-1:IDX_W] : pend_q[ADDR_W-1:IDX_W];
  assign fill_st_o  = (fsm_q == F_EVICT) ? LS_I : (wr_q ? LS_M : LS_S);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q  <= F_IDLE;
      pend_q <= '0;
      vic_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      unique case (fsm_q)
        F_IDLE: if (miss_o) begin
          pend_q <= req_addr_i;
          wr_q   <= req_write_i;
          vic_q  <= {cur_tag_i, req_addr_i[IDX_W-1:0]};
          fsm_q  <= need_wb ? F_EVICT : F_FETCH;
        end
        F_EVICT: if (bus_done_i) fsm_q <= F_FETCH;
        F_FETCH: if (bus_done_i) fsm_q <= F_IDLE;
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl import msi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int LINES = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 hit_o,
  output logic                 miss_o,
  output logic                 busy_o,
  output logic                 bus_req_o,
  output logic [1:0]           bus_op_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  input  logic                 bus_done_i,
  input  logic                 snp_valid_i,
  input  logic [1:0]           snp_op_i,
  input  logic [ADDR_W-1:0]    snp_addr_i,
  output logic                 flush_o,
  output logic [ADDR_W-1:0]    flush_addr_o,
  output logic [2*LINES-1:0]   line_st_o
);
  logic [LINES-1:0][1:0]       st_vec;
  logic [LINES-1:0][TAG_W-1:0] tag_vec;
  logic                        fill_en;
  logic [IDX_W-1:0]            fill_idx;
  logic [TAG_W-1:0]            fill_tag;
  line_st_e                    fill_st;
  bus_op_e                     op;
  logic [IDX_W-1:0]            req_idx;

  assign req_idx = req_addr_i[IDX_W-1:0];

  msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
    .clk_i, .rst_ni,
    .snp_valid_i,
    .snp_op_i   (bus_op_e'(snp_op_i)),
    .snp_idx_i  (snp_addr_i[IDX_W-1:0]),
    .snp_tag_i  (snp_addr_i[ADDR_W-1:IDX_W]),
    .fill_en_i  (fill_en),
    .fill_idx_i (fill_idx),
    .fill_tag_i (fill_tag),
    .fill_st_i  (fill_st),
    .st_o       (st_vec),
    .tag_o      (tag_vec),
    .flush_o
  );

  msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i,
    .cur_st_i   (line_st_e'(st_vec[req_idx])),
    .cur_tag_i  (tag_vec[req_idx]),
    .bus_done_i,
    .hit_o, .miss_o, .busy_o, .bus_req_o,
    .bus_op_o   (op),
    .bus_addr_o,
    .fill_en_o  (fill_en),
    .fill_idx_o (fill_idx),
    .fill_tag_o (fill_tag),
    .fill_st_o  (fill_st)
  );

  assign bus_op_o     = op;
  assign flush_addr_o = snp_addr_i;
  assign line_st_o    = st_vec;
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int LINES = 1 << IDX_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_write_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               hit_o,
  input logic               miss_o,
  input logic               busy_o,
  input logic               bus_req_o,
  input logic [1:0]         bus_op_o,
  input logic [ADDR_W-1:0]  bus_addr_o,
  input logic               bus_done_i,
  input logic               snp_valid_i,
  input logic [1:0]         snp_op_i,
  input logic [ADDR_W-1:0]  snp_addr_i,
  input logic               flush_o,
  input logic [ADDR_W-1:0]  flush_addr_o,
  input logic [2*LINES-1:0] line_st_o
);
  logic [1:0]       st_a [LINES];
  logic [IDX_W-1:0] bidx, sidx;

  for (genvar g = 0; g < LINES; g++) begin : g_st
    assign st_a[g] = line_st_o[2*g +: 2];
  end
  assign bidx = bus_addr_o[IDX_W-1:0];
  assign sidx = snp_addr_i[IDX_W-1:0];

  p_reset_clear_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (line_st_o == '0) && !bus_req_o && !busy_o);

  p_rd_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_op_o == 2'd1 && bus_done_i |=> st_a[$past(bidx)] == 2'd1);

  p_rdx_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_op_o == 2'd2 && bus_done_i |=> st_a[$past(bidx)] == 2'd2);

  p_hit_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !busy_o && !bus_req_o && !miss_o);

  p_wb_victim_dirty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_op_o == 2'd3 |-> st_a[bidx] == 2'd2);

  p_wb_then_fetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_op_o == 2'd3 && bus_done_i |=>
      st_a[$past(bidx)] == 2'd0 && bus_req_o && bus_op_o != 2'd3);

  p_snp_rd_demote_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o && snp_op_i == 2'd1 && !bus_done_i |=> st_a[$past(sidx)] == 2'd1);

  p_snp_rdx_inval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o && snp_op_i == 2'd2 && !bus_done_i |=> st_a[$past(sidx)] == 2'd0);

  p_flush_only_dirty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> snp_valid_i && (snp_op_i == 2'd1 || snp_op_i == 2'd2) &&
                st_a[sidx] == 2'd2 && flush_addr_o == snp_addr_i);

  p_hold_until_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_op_o) && $stable(bus_addr_o));

  p_busy_while_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/msi_snoop_ctrl_test.sv
module msi_snoop_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       req_valid_i = 0, req_write_i = 0;
  logic [7:0] req_addr_i = '0;
  logic       hit_o, miss_o, busy_o, bus_req_o, flush_o;
  logic [1:0] bus_op_o;
  logic [7:0] bus_addr_o, flush_addr_o;
  logic       bus_done_i = 0, snp_valid_i = 0;
  logic [1:0] snp_op_i = '0;
  logic [7:0] snp_addr_i = '0;
  logic [7:0] line_st_o;

  int n_chk = 0, n_bad = 0;
  int exp_st [4];
  logic [5:0] exp_tag [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_snoop_ctrl uut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_write_i, .req_addr_i,
    .hit_o, .miss_o, .busy_o, .bus_req_o, .bus_op_o, .bus_addr_o, .bus_done_i,
    .snp_valid_i, .snp_op_i, .snp_addr_i, .flush_o, .flush_addr_o, .line_st_o
  );

  function automatic int lst(input int i);
    return int'(line_st_o[2*i +: 2]);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic chk_all(input string rq);
    for (int i = 0; i < 4; i++) chk(lst(i) == exp_st[i], rq, lst(i), exp_st[i]);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req_valid_i = 0; bus_done_i = 0; snp_valid_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin exp_st[i] = 0; exp_tag[i] = '0; end
    #1;
    chk(line_st_o == '0, "R1", int'(line_st_o), 0);
    chk(!busy_o && !bus_req_o, "R1", int'({busy_o, bus_req_o}), 0);
  endtask

  task automatic do_access(input bit wr, input logic [7:0] addr);
    int idx = int'(addr[1:0]);
    logic [5:0] tg = addr[7:2];
    bit present = exp_st[idx] != 0 && exp_tag[idx] == tg;
    bit ok = present && (!wr || exp_st[idx] == 2);
    bit wb = !present && exp_st[idx] == 2;
    int fop = wr ? 2 : 1;
    string frq = wr ? "R3" : "R2";
    @(negedge clk);
    req_valid_i = 1; req_write_i = wr; req_addr_i = addr;
    #1;
    if (ok) begin
      chk(hit_o && !busy_o && !bus_req_o, "R4", int'({hit_o, busy_o, bus_req_o}), 4);
      @(negedge clk); #1;
      chk(lst(idx) == exp_st[idx], "R4", lst(idx), exp_st[idx]);
    end else begin
      chk(miss_o && busy_o && !hit_o, "R9", int'({miss_o, busy_o, hit_o}), 6);
      @(negedge clk); #1;
      if (wb) begin
        chk(bus_req_o && bus_op_o == 2'd3, "R5", int'(bus_op_o), 3);
        chk(bus_addr_o == {exp_tag[idx], 2'(idx)}, "R5", int'(bus_addr_o), int'({exp_tag[idx], 2'(idx)}));
        @(negedge clk); #1;
        chk(bus_req_o && busy_o && bus_op_o == 2'd3, "R9", int'(bus_op_o), 3);
        bus_done_i = 1;
        @(negedge clk);
        bus_done_i = 0; #1;
        chk(lst(idx) == 0, "R5", lst(idx), 0);
        exp_st[idx] = 0;
      end
      chk(bus_req_o && int'(bus_op_o) == fop, frq, int'(bus_op_o), fop);
      chk(bus_addr_o == addr, frq, int'(bus_addr_o), int'(addr));
      repeat (2) begin
        @(negedge clk); #1;
        chk(busy_o && bus_req_o && int'(bus_op_o) == fop && bus_addr_o == addr, "R9",
            int'({busy_o, bus_req_o}), 3);
      end
      bus_done_i = 1;
      @(negedge clk);
      bus_done_i = 0; #1;
      exp_st[idx] = fop; exp_tag[idx] = tg;
      chk(lst(idx) == fop, frq, lst(idx), fop);
      chk(hit_o && !busy_o && !bus_req_o, "R4", int'({hit_o, busy_o, bus_req_o}), 4);
    end
    @(negedge clk);
    req_valid_i = 0;
  endtask

  task automatic do_snoop(input int op, input logic [7:0] addr);
    int idx = int'(addr[1:0]);
    bit match = exp_st[idx] != 0 && exp_tag[idx] == addr[7:2];
    bit fl = match && exp_st[idx] == 2 && (op == 1 || op == 2);
    int nxt = exp_st[idx];
    string rq = "R8";
    if (match && op == 2) begin nxt = 0; rq = "R7"; end
    else if (match && op == 1 && exp_st[idx] == 2) begin nxt = 1; rq = "R6"; end
    @(negedge clk);
    snp_valid_i = 1; snp_op_i = 2'(op); snp_addr_i = addr;
    #1;
    chk(flush_o == fl, rq, int'(flush_o), int'(fl));
    if (fl) chk(flush_addr_o == addr, rq, int'(flush_addr_o), int'(addr));
    @(negedge clk);
    snp_valid_i = 0; #1;
    exp_st[idx] = nxt;
    chk_all(rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // local request sweep: index x start state x kind x tag
    for (int idx = 0; idx < 4; idx++)
      for (int s = 0; s < 3; s++)
        for (int wr = 0; wr < 2; wr++)
          for (int same = 0; same < 2; same++) begin
            logic [5:0] ta = 6'(idx * 5 + 3);
            logic [5:0] tb = ta ^ 6'h2A;
            do_reset();
            if (s == 1) do_access(1'b0, {ta, 2'(idx)});
            if (s == 2) do_access(1'b1, {ta, 2'(idx)});
            do_access(wr[0], {same ? ta : tb, 2'(idx)});
            chk_all(wr ? "R3" : "R2");
          end
    // snoop sweep: index x start state x op x tag
    for (int idx = 0; idx < 4; idx++)
      for (int s = 0; s < 3; s++)
        for (int op = 1; op < 4; op++)
          for (int same = 0; same < 2; same++) begin
            logic [5:0] ta = 6'(idx * 7 + 1);
            do_reset();
            do_access(1'b0, {6'h3F - ta, 2'((idx + 1) % 4)});
            if (s == 1) do_access(1'b0, {ta, 2'(idx)});
            if (s == 2) do_access(1'b1, {ta, 2'(idx)});
            do_snoop(op, {same ? ta : ta ^ 6'h15, 2'(idx)});
          end
    summary();
    $finish;
  end
endmodule